// File: doc/BRIEF.md
# Segment Descriptor Access Verifier

This unit answers one of four privilege queries about a 16-bit segment selector: it can load the access-rights word, load the segment limit, test whether the segment is readable, or test whether it is writable. It is given the current privilege level and the base and limit of both descriptor tables. It first screens the selector, then fetches the descriptor words it needs through a request/acknowledge read port. It reports a zero flag, and for the two load queries it also reports a destination value.

A caller presents the selector, the query code, the operand size and the privilege level with a one-cycle `start`. The unit raises `done` for exactly one cycle when it has finished. On that cycle `zeroFlag` holds the verdict, and `destWe` says whether `destOut` should be written into the destination register. A memory abort during either read cancels the query. After an abort the unit is idle again, it gives no `done`, and it keeps its previous outputs.

Top module: `segAccessVerifier`

## Requirements
- R1: A selector whose bits 15:2 are all zero is treated as null. The query finishes with `zeroFlag`=0 and `destWe`=0, and no memory request is made.
- R2: Selector bit 2 chooses the table: 1 selects the local table and 0 selects the global table. When `{selector[15:3],3'b000}` is not below that table's limit, the query finishes with `zeroFlag`=0 and no memory request.
- R3: The first read is a 32-bit read (`memSize32`=1) at table base + `{selector[15:3],3'b000}` + 4. Only a passing limit query makes a second read, a 16-bit read (`memSize32`=0, data in `memRdata[15:0]`) at offset +0. `memReq` holds its address and size until `memAck` or `memAbort`.
- R4: Query code 0 (load rights) fails when the type field (bits 12:8 of the word at +4) is 0x00, 0x08, 0x0A or 0x0D. It also fails when the descriptor is not conforming code (bits 12:10 not 111) and its DPL (bits 14:13) is below the CPL or below the selector RPL (bits 1:0).
- R5: Query code 1 (load limit) fails on any gate (bit 12 clear and bit 10 set) and on type 0x00 or 0x0A. It applies the same privilege rule as R4.
- R6: A passing load-rights query returns the 32-bit word at +4 masked with 0x00FFFF00 when `opSize32`=1. When `opSize32`=0 it returns that word's low half masked with 0xFF00, zero-extended.
- R7: With `opSize32`=1, a passing load-limit query returns `{byte6[3:0], word0}`. When bit 7 of byte +6 is set, that value is instead shifted left by 12 and ORed with 0xFFF. With `opSize32`=0 it returns only `word0`.
- R8: Query code 2 (readable) requires bit 12 set and fails on execute-only code (bit 11 set, bit 9 clear). It applies the privilege rule unless bits 11:10 are both set.
- R9: Query code 3 (writable) requires bit 12 set and always applies the privilege rule. It fails on code (bit 11 set) and on data with bit 9 clear.
- R10: `zeroFlag` changes only on a `done` cycle and is 1 only when every check of the query passes. `destWe` is 1 only for a passing load query, and the verify queries never assert it.
- R11: `memAbort` during a pending read drops `memReq` at the next edge, returns the unit to idle, produces no `done`, and leaves `zeroFlag` as it was.
- R12: `done` is a single-cycle pulse. A `start` that arrives while a query is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a query; ignored while busy |
| subOp | input | 2 | 0 load rights, 1 load limit, 2 readable, 3 writable |
| opSize32 | input | 1 | 1 selects a 32-bit result, 0 a 16-bit result |
| selector | input | 16 | Segment selector under test |
| cpl | input | 2 | Current privilege level |
| gdtBase | input | ADDR_W | Global table base |
| gdtLimit | input | ADDR_W | Global table limit |
| ldtBase | input | ADDR_W | Local table base |
| ldtLimit | input | ADDR_W | Local table limit |
| memReq | output | 1 | Read request, held until ack or abort |
| memAddr | output | ADDR_W | Read byte address |
| memSize32 | output | 1 | 1 for a 32-bit read, 0 for a 16-bit read |
| memAck | input | 1 | Read data valid this cycle |
| memAbort | input | 1 | Cancel the pending read and the query |
| memRdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| zeroFlag | output | 1 | Verdict: 1 when the query passed |
| destWe | output | 1 | Write `destOut` to the destination (with `done`) |
| destOut | output | 32 | Result of a load query |

## Verification
The bound checker watches the read handshake and the completion pulse on every cycle. It checks that a request keeps its address and size until it is answered, that an abort removes the request without completing the query, and that `done` lasts one cycle and never coincides with a request. It also checks that `zeroFlag` only moves on a `done` cycle and that `destWe` comes only with a passing verdict. The bench alone can show that the type rules, the conforming-segment exceptions, the privilege comparison, the granularity scaling and the result masks give the right values. It compares random descriptor tables and random selectors against its own model, together with directed gate, conforming-code, null, out-of-range, abort and busy-start cases.

// File: rtl/segVerifyPkg.sv
package segVerifyPkg;

  typedef enum logic [1:0] {
    OP_RIGHTS = 2'd0,
    OP_LIMIT  = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } verifyOp_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_EVAL  = 3'd1,
    ST_RDHI  = 3'd2,
    ST_JUDGE = 3'd3,
    ST_RDLO  = 3'd4
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;    // capture query inputs
    logic captureHi;  // capture dword at +4
    logic selLo;      // address the word at +0
    logic finFail;    // finish with early reject
    logic finHi;      // finish after judging the +4 dword
    logic finLo;      // finish with the limit word
  } ctrlStrobe_t;

endpackage

// File: rtl/segTypeRules.sv
module segTypeRules
  import segVerifyPkg::*;
(
  input  verifyOp_e   op,
  input  logic [15:0] accWord,
  input  logic [1:0]  cpl,
  input  logic [1:0]  rpl,
  output logic        pass
);

  logic [4:0] typeField;
  logic [1:0] dpl;
  logic       privFail;
  logic       notConforming;

  assign typeField     = accWord[12:8];
  assign dpl           = accWord[14:13];
  assign privFail      = (dpl < cpl) || (dpl < rpl);
  assign notConforming = (accWord[12:10] != 3'b111);

  always_comb begin
    pass = 1'b1;
    unique case (op)
      OP_RIGHTS: begin
        if (typeField == 5'h00 || typeField == 5'h08 ||
            typeField == 5'h0A || typeField == 5'h0D) pass = 1'b0;
        if (notConforming && privFail) pass = 1'b0;
      end
      OP_LIMIT: begin
        if (!accWord[12] && accWord[10]) pass = 1'b0;
        if (typeField == 5'h00 || typeField == 5'h0A) pass = 1'b0;
        if (notConforming && privFail) pass = 1'b0;
      end
      OP_READ: begin
        if (!accWord[12]) pass = 1'b0;
        if ((accWord[11:10] != 2'b11) && privFail) pass = 1'b0;
        if (accWord[11] && !accWord[9]) pass = 1'b0;
      end
      OP_WRITE: begin
        if (!accWord[12]) pass = 1'b0;
        if (privFail) pass = 1'b0;
        if (accWord[11]) pass = 1'b0;
        if (!accWord[9]) pass = 1'b0;
      end
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/segVerifyCtrl.sv
module segVerifyCtrl
  import segVerifyPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  input  logic        memAbort,
  input  logic        earlyReject,
  input  logic        hiPass,
  input  logic        isLimitOp,
  output ctrlStrobe_t strobe,
  output logic        memReq,
  output logic        done
);

  ctrlState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    memReq = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.latchOp = 1'b1;
          stateD = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (earlyReject) begin
          strobe.finFail = 1'b1;
          stateD = ST_IDLE;
        end else begin
          stateD = ST_RDHI;
        end
      end
      ST_RDHI: begin
        memReq = 1'b1;
        if (memAbort) begin
          stateD = ST_IDLE;
        end else if (memAck) begin
          strobe.captureHi = 1'b1;
          stateD = ST_JUDGE;
        end
      end
      ST_JUDGE: begin
        if (hiPass && isLimitOp) begin
          stateD = ST_RDLO;
        end else begin
          strobe.finHi = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_RDLO: begin
        memReq = 1'b1;
        strobe.selLo = 1'b1;
        if (memAbort) begin
          stateD = ST_IDLE;
        end else if (memAck) begin
          strobe.finLo = 1'b1;
          stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      stateQ <= stateD;
      done   <= strobe.finFail | strobe.finHi | strobe.finLo;
    end
  end

endmodule

// File: rtl/segVerifyDatapath.sv
module segVerifyDatapath
  import segVerifyPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [1:0]        subOp,
  input  logic              opSize32,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [ADDR_W-1:0] ldtLimit,
  input  logic [31:0]       memRdata,
  output logic              earlyReject,
  output logic              hiPass,
  output logic              isLimitOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSize32,
  output logic              zeroFlag,
  output logic              destWe,
  output logic [31:0]       destOut
);

  localparam int PAD_W = ADDR_W - 16;
  localparam logic [ADDR_W-1:0] HI_OFFSET = ADDR_W'(4);

  verifyOp_e   opQ;
  logic        sizeQ;
  logic [15:0] selQ;
  logic [1:0]  cplQ;
  logic [31:0] hiQ;

  logic [ADDR_W-1:0] idxOff, tblBase, tblLimit;
  logic [31:0] rightsVal, limitVal;
  logic [19:0] rawLimit;
  logic [7:0]  byteSix;

  assign idxOff   = {{PAD_W{1'b0}}, selQ[15:3], 3'b000};
  assign tblBase  = selQ[2] ? ldtBase  : gdtBase;
  assign tblLimit = selQ[2] ? ldtLimit : gdtLimit;

  assign earlyReject = (selQ[15:2] == 14'd0) || (idxOff >= tblLimit);
  assign isLimitOp   = (opQ == OP_LIMIT);
  assign memAddr     = tblBase + idxOff + (strobe.selLo ? '0 : HI_OFFSET);
  assign memSize32   = !strobe.selLo;

  segTypeRules u_rules (
    .op      (opQ),
    .accWord (hiQ[15:0]),
    .cpl     (cplQ),
    .rpl     (selQ[1:0]),
    .pass    (hiPass)
  );

  assign byteSix   = hiQ[23:16];
  assign rightsVal = sizeQ ? (hiQ & 32'h00FF_FF00) : {16'd0, hiQ[15:8], 8'd0};
  assign rawLimit  = {byteSix[3:0], memRdata[15:0]};
  assign limitVal  = !sizeQ     ? {16'd0, memRdata[15:0]} :
                     byteSix[7] ? {rawLimit, 12'hFFF} : {12'd0, rawLimit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_RIGHTS;
      sizeQ <= 1'b0;
      selQ  <= '0;
      cplQ  <= '0;
      hiQ   <= '0;
    end else begin
      if (strobe.latchOp) begin
        opQ   <= verifyOp_e'(subOp);
        sizeQ <= opSize32;
        selQ  <= selector;
        cplQ  <= cpl;
      end
      if (strobe.captureHi) hiQ <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroFlag <= 1'b0;
      destWe   <= 1'b0;
      destOut  <= '0;
    end else begin
      destWe <= 1'b0;
      if (strobe.finFail) zeroFlag <= 1'b0;
      if (strobe.finHi) begin
        zeroFlag <= hiPass;
        if (hiPass && opQ == OP_RIGHTS) begin
          destWe  <= 1'b1;
          destOut <= rightsVal;
        end
      end
      if (strobe.finLo) begin
        zeroFlag <= 1'b1;
        destWe   <= 1'b1;
        destOut  <= limitVal;
      end
    end
  end

endmodule

// File: rtl/segAccessVerifier.sv
module segAccessVerifier
  import segVerifyPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        subOp,
  input  logic              opSize32,
  input  logic [15:0]       selector,
  input  logic [1:0]        cpl,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [ADDR_W-1:0] gdtLimit,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [ADDR_W-1:0] ldtLimit,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSize32,
  input  logic              memAck,
  input  logic              memAbort,
  input  logic [31:0]       memRdata,
  output logic              done,
  output logic              zeroFlag,
  output logic              destWe,
  output logic [31:0]       destOut
);

  ctrlStrobe_t strobe;
  logic earlyReject, hiPass, isLimitOp;

  segVerifyCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .memAck      (memAck),
    .memAbort    (memAbort),
    .earlyReject (earlyReject),
    .hiPass      (hiPass),
    .isLimitOp   (isLimitOp),
    .strobe      (strobe),
    .memReq      (memReq),
    .done        (done)
  );

  segVerifyDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .subOp       (subOp),
    .opSize32    (opSize32),
    .selector    (selector),
    .cpl         (cpl),
    .gdtBase     (gdtBase),
    .gdtLimit    (gdtLimit),
    .ldtBase     (ldtBase),
    .ldtLimit    (ldtLimit),
    .memRdata    (memRdata),
    .earlyReject (earlyReject),
    .hiPass      (hiPass),
    .isLimitOp   (isLimitOp),
    .memAddr     (memAddr),
    .memSize32   (memSize32),
    .zeroFlag    (zeroFlag),
    .destWe      (destWe),
    .destOut     (destOut)
  );

endmodule

// File: rtl/segVerifyChk.sv
module segVerifyChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memSize32,
  input logic              memAck,
  input logic              memAbort,
  input logic              done,
  input logic              zeroFlag,
  input logic              destWe
);

  // R12
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12
  no_req_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memAbort) |=> (memReq && $stable(memAddr) && $stable(memSize32)));

  // R11
  abort_cancels_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAbort) |=> (!memReq && !done));

  // R10
  zf_moves_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(zeroFlag) |-> done);

  // R10
  dest_needs_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    destWe |-> (done && zeroFlag));

endmodule

bind segAccessVerifier segVerifyChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memSize32 (memSize32),
  .memAck    (memAck),
  .memAbort  (memAbort),
  .done      (done),
  .zeroFlag  (zeroFlag),
  .destWe    (destWe)
);

// File: tb/segAccessVerifier_tb.sv
module segAccessVerifier_tb;

  localparam logic [31:0] GDT_BASE = 32'h0001_0000;
  localparam logic [31:0] LDT_BASE = 32'h0002_0000;
  localparam logic [31:0] GDT_LIM  = 32'h0000_0060;
  localparam logic [31:0] LDT_LIM  = 32'h0000_0040;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  subOp = '0;
  logic        opSize32 = 1'b0;
  logic [15:0] selector = '0;
  logic [1:0]  cpl = '0;
  logic        memReq, memSize32, done, zeroFlag, destWe;
  logic [31:0] memAddr, destOut;
  logic        memAck = 1'b0, memAbort = 1'b0;
  logic [31:0] memRdata = '0;

  logic [63:0] gdtTab [16];
  logic [63:0] ldtTab [16];

  int checks = 0;
  int fails = 0;
  int doneCount = 0;
  int abortMode = 0;     // 0 none, 1 next read, 2 next 16-bit read
  bit abortFired = 0;
  bit sawReq = 0;
  logic [31:0] hiAddrSeen, loAddrSeen;

  always #10 clk = ~clk;

  segAccessVerifier u_dut (
    .clk(clk), .rstN(rstN), .start(start), .subOp(subOp), .opSize32(opSize32),
    .selector(selector), .cpl(cpl), .gdtBase(GDT_BASE), .gdtLimit(GDT_LIM),
    .ldtBase(LDT_BASE), .ldtLimit(LDT_LIM), .memReq(memReq), .memAddr(memAddr),
    .memSize32(memSize32), .memAck(memAck), .memAbort(memAbort), .memRdata(memRdata),
    .done(done), .zeroFlag(zeroFlag), .destWe(destWe), .destOut(destOut)
  );

  function automatic logic [31:0] memLookup(input logic [31:0] a);
    logic [63:0] d;
    if (a >= LDT_BASE && a < LDT_BASE + 32'd128) d = ldtTab[a[6:3]];
    else if (a >= GDT_BASE && a < GDT_BASE + 32'd128) d = gdtTab[a[6:3]];
    else return 32'hDEAD_BEEF;
    if (a[2:0] == 3'd4) return d[63:32];
    if (a[2:0] == 3'd0) return d[31:0];
    return 32'hBAD0_BAD0;
  endfunction

  // returns {pass, write, value}
  function automatic logic [33:0] model(input logic [15:0] s, input logic [1:0] op,
                                        input logic sz, input logic [1:0] c);
    logic [63:0] d;
    logic [15:0] h;
    logic [4:0]  t;
    logic [1:0]  dpl;
    logic        priv, ok, we;
    logic [31:0] v, lim;
    logic [19:0] raw;
    if (s[15:2] == 14'd0) return 34'd0;
    lim = s[2] ? LDT_LIM : GDT_LIM;
    if ({16'd0, s[15:3], 3'b000} >= lim) return 34'd0;
    d = s[2] ? ldtTab[s[6:3]] : gdtTab[s[6:3]];
    h = d[47:32];
    t = h[12:8];
    dpl = h[14:13];
    priv = (dpl < c) || (dpl < s[1:0]);
    v = '0;
    ok = 1'b0;
    case (op)
      2'd0: begin
        ok = !(t == 5'h00 || t == 5'h08 || t == 5'h0A || t == 5'h0D) &&
             !(h[12:10] != 3'b111 && priv);
        v = sz ? (d[63:32] & 32'h00FF_FF00) : {16'd0, h & 16'hFF00};
      end
      2'd1: begin
        ok = !((!h[12] && h[10]) || t == 5'h00 || t == 5'h0A) &&
             !(h[12:10] != 3'b111 && priv);
        raw = {d[51:48], d[15:0]};
        v = !sz ? {16'd0, d[15:0]} : (d[55] ? {raw, 12'hFFF} : {12'd0, raw});
      end
      2'd2: ok = h[12] && !(h[11:10] != 2'b11 && priv) && !(h[11] && !h[9]);
      default: ok = h[12] && !priv && !h[11] && h[9];
    endcase
    we = ok && (op < 2'd2);
    return {ok, we, we ? v : 32'd0};
  endfunction

  task automatic check(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // memory responder and done counter, all at negedge
  initial begin
    forever begin
      @(negedge clk);
      if (done) doneCount++;
      memAck = 1'b0;
      memAbort = 1'b0;
      if (memReq) begin
        sawReq = 1;
        if (memSize32) hiAddrSeen = memAddr; else loAddrSeen = memAddr;
        if (abortMode == 1 || (abortMode == 2 && !memSize32)) begin
          memAbort = 1'b1;
          abortMode = 0;
          abortFired = 1;
        end else if (($urandom % 3) != 0) begin
          memAck = 1'b1;
          memRdata = memLookup(memAddr);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  task automatic pulseStart(input logic [15:0] s, input logic [1:0] op, input logic sz,
                            input logic [1:0] c);
    @(negedge clk);
    selector = s; subOp = op; opSize32 = sz; cpl = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    ok = done;
  endtask

  task automatic runOp(input logic [15:0] s, input logic [1:0] op, input logic sz,
                       input logic [1:0] c, input string req);
    logic [33:0] e;
    bit ok;
    e = model(s, op, sz, c);
    pulseStart(s, op, sz, c);
    waitDone(ok);
    check(ok, {req, " done"}, {31'd0, ok}, 32'd1);
    if (ok) begin
      check(zeroFlag == e[33], {req, " zf"}, {31'd0, zeroFlag}, {31'd0, e[33]});
      check(destWe == e[32], {req, " R10 we"}, {31'd0, destWe}, {31'd0, e[32]});
      if (e[32]) check(destOut == e[31:0], {req, " value"}, destOut, e[31:0]);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) begin
      gdtTab[i] = {$urandom, $urandom};
      ldtTab[i] = {$urandom, $urandom};
    end
    gdtTab[1] = {8'h00, 8'h8A, 8'h92, 8'h00, 16'h0000, 16'h1234};  // granular data
    gdtTab[2] = {8'h00, 8'h00, 8'h9E, 8'h00, 32'h0000_FFFF};        // conforming readable code dpl0
    gdtTab[3] = {8'h12, 8'h4F, 8'hF2, 8'h34, 32'h0000_00FF};        // writable data dpl3
    gdtTab[4] = {8'h00, 8'h00, 8'hEC, 8'h00, 32'h0000_0010};        // gate dpl3
    gdtTab[5] = {8'h00, 8'h00, 8'hB2, 8'h00, 32'h0000_0020};        // data dpl1

    repeat (3) @(negedge clk);
    check(!done && !zeroFlag && !destWe && !memReq, "reset",
          {28'd0, done, zeroFlag, destWe, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 null selector, no read
    sawReq = 0;
    runOp(16'h0003, 2'd0, 1'b1, 2'd0, "R1 null");
    check(!sawReq, "R1 no read", {31'd0, sawReq}, 32'd0);

    // R2 out of range in both tables
    sawReq = 0;
    runOp(16'h0060, 2'd2, 1'b0, 2'd0, "R2 gdt range");
    runOp(16'h0044, 2'd1, 1'b1, 2'd0, "R2 ldt range");
    check(!sawReq, "R2 no read", {31'd0, sawReq}, 32'd0);

    // R7 granular limit, R3 addresses
    runOp(16'h0008, 2'd1, 1'b1, 2'd0, "R7 granular");
    check(destOut == 32'hA123_4FFF, "R7 literal", destOut, 32'hA123_4FFF);
    check(hiAddrSeen == GDT_BASE + 32'h0C, "R3 hi addr", hiAddrSeen, GDT_BASE + 32'h0C);
    check(loAddrSeen == GDT_BASE + 32'h08, "R3 lo addr", loAddrSeen, GDT_BASE + 32'h08);
    runOp(16'h0008, 2'd1, 1'b0, 2'd0, "R7 16-bit");

    // R8 / R9 conforming code, writable data
    runOp(16'h0013, 2'd2, 1'b0, 2'd3, "R8 conforming readable");
    runOp(16'h0013, 2'd3, 1'b0, 2'd3, "R9 code not writable");
    runOp(16'h001B, 2'd3, 1'b0, 2'd3, "R9 writable");
    runOp(16'h001B, 2'd0, 1'b1, 2'd3, "R6 rights32");
    check(destOut == 32'h004F_F200, "R6 literal", destOut, 32'h004F_F200);
    // R5 gate rejected, R4 gate accepted
    runOp(16'h0023, 2'd1, 1'b1, 2'd3, "R5 gate");
    runOp(16'h0023, 2'd0, 1'b0, 2'd3, "R4 gate rights16");
    runOp(16'h002A, 2'd0, 1'b1, 2'd2, "R4 privilege");

    // R11 abort during first read and during limit read
    begin
      logic prevZf;
      int prevDone;
      prevZf = zeroFlag;
      prevDone = doneCount;
      abortMode = 1; abortFired = 0;
      pulseStart(16'h001B, 2'd0, 1'b1, 2'd3);
      repeat (20) @(negedge clk);
      check(abortFired && doneCount == prevDone, "R11 no done",
            doneCount - prevDone, 32'd0);
      check(zeroFlag == prevZf, "R11 zf kept", {31'd0, zeroFlag}, {31'd0, prevZf});
      prevDone = doneCount;
      abortMode = 2; abortFired = 0;
      pulseStart(16'h0008, 2'd1, 1'b1, 2'd0);
      repeat (20) @(negedge clk);
      check(abortFired && doneCount == prevDone && !memReq, "R11 lo abort",
            doneCount - prevDone, 32'd0);
      runOp(16'h001B, 2'd3, 1'b0, 2'd3, "R11 recovers");
    end

    // R12 start while busy ignored
    begin
      logic [33:0] e;
      int prevDone;
      bit ok;
      e = model(16'h0008, 2'd1, 1'b1, 2'd0);
      prevDone = doneCount;
      pulseStart(16'h0008, 2'd1, 1'b1, 2'd0);
      selector = 16'h0013; subOp = 2'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waitDone(ok);
      check(ok && zeroFlag == e[33] && destOut == e[31:0], "R12 busy start",
            destOut, e[31:0]);
      repeat (20) @(negedge clk);
      check(doneCount - prevDone == 1, "R12 one done", doneCount - prevDone, 32'd1);
    end

    // random mix covering R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < 400; k++) begin
      logic [15:0] s;
      s = {9'd0, 4'($urandom % 16), 1'($urandom), 2'($urandom)};
      if ($urandom % 10 == 0) s = {14'd0, 2'($urandom)};
      runOp(s, 2'($urandom), 1'($urandom), 2'($urandom), "R10 random");
    end

    finishRun();
  end

endmodule